// File: doc/BRIEF.md
# Three-Operand Register Field Decoder

This block turns the 16-bit register-specifier field of a three-register ALU instruction into three 6-bit register-file addresses. The destination is Rc and the sources are Ra and Rb. The field carries a 4-bit group code and three 4-bit offsets. The group code selects one of sixteen permitted pairings of register groups. Each offset picks a slot within the group chosen for its operand.

The register space has four groups of sixteen slots:

- Auxiliary (A): twelve auxiliary registers followed by four stack-option slots.
- Local (L): sixteen local registers.
- Extra (X): twelve extra registers followed by four stack-option slots.
- Constant (C): sixteen constants.

A stack-option slot means the same thing whether it is reached through A or through X. The decoder therefore gives it one canonical address and raises a per-operand stack flag.

Two of the sixteen codes are literal codes. In a literal code the Ra and Rb offsets together form an 8-bit immediate. The left operand becomes a fixed value: zero by default, or 511 when a parameter selects that variant.

The decoder is purely combinational. It sits between instruction fetch and register-file read. The register file, the stack-pointer arithmetic and the ALU are outside this block.

Top module: `tri_reg_spec_decoder`

## Requirements
- R1: The field layout is:
  - bits [15:12]: group code
  - bits [11:8]: Rc offset
  - bits [7:4]: Ra offset
  - bits [3:0]: Rb offset

  Each address is {group[1:0], offset[3:0]}, with A=00, L=01, X=10 and C=11.
- R2: The group code maps each (Rc, Ra, Rb) operand to a group as follows:

  | Code | Rc | Ra | Rb |
  |------|----|----|----|
  | 0 | A | A | A |
  | 1 | A | C | A |
  | 2 | L | L | L |
  | 3 | L | L | X |
  | 4 | L | X | L |
  | 5 | L | X | X |
  | 6 | L | C | L |
  | 7 | L | C | X |
  | 8 | L | literal | literal |
  | 9 | X | L | L |
  | 10 | X | L | X |
  | 11 | X | X | L |
  | 12 | X | X | X |
  | 13 | X | C | L |
  | 14 | X | C | X |
  | 15 | X | literal | literal |
- R3: The Rc address never lies in group C. The Rb address lies in group C only under a literal code.
- R4: No code yields one operand in group A (not a stack option) together with another operand in group L or X (not a stack option).
- R5: An offset of 12 to 15 in group A or X is a stack option. The operand's stack flag is 1 and its address is {00, offset}, so the same offset reached through X gives the same address as through A.
- R6: Offsets 0 to 11 in groups A and X, and every offset in groups L and C, clear the stack flag.
- R7: Under a literal code (8 or 15):
  - lit_valid_o is 1.
  - lit_value_o is {Ra offset, Rb offset}.
  - The Ra and Rb addresses are both {11, 0000}, the constant-zero slot.
  - lit_left_o is 0, or 511 when the variant parameter is set.
- R8: Under every non-literal code, lit_valid_o, lit_value_o and lit_left_o are all 0.
- R9: Under a literal code, the Rc address still takes its offset from bits [11:8]. All outputs follow a change of the field without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| field_i | input | 16 | Register-specifier field of the instruction |
| rc_addr_o | output | 6 | Destination register address |
| ra_addr_o | output | 6 | First source register address |
| rb_addr_o | output | 6 | Second source register address |
| rc_stack_o | output | 1 | Destination is a stack option |
| ra_stack_o | output | 1 | First source is a stack option |
| rb_stack_o | output | 1 | Second source is a stack option |
| lit_valid_o | output | 1 | Literal code is active |
| lit_value_o | output | 8 | 8-bit immediate from the Ra and Rb offsets |
| lit_left_o | output | 9 | Fixed left operand under a literal code |

## Verification
Each of the sixteen group codes is applied with three offset patterns:

- Low offsets (1, 2, 3) test the group bits of ordinary registers.
- High offsets (13 to 15) turn every A or X slot into a stack option and show canonical addressing.
- A mixed pattern (11, 12, 0) places the boundary between the last register and the first stack slot on different operands.

Directed cases cover the following:

- Stack offsets give the same address through X as through A.
- Offsets 12 to 15 in group L are not stack options.
- The literal extremes 0x00 and 0xFF are decoded correctly.
- The Rc offset is kept under a literal code.
- The outputs change without a clock.

// File: rtl/trs_pkg.sv
// Package: shared types and the group-code table of the register field decoder.
// Assumes a 4-bit group code (16 combinations); offset width is set per module.
package trs_pkg;

    typedef enum logic [1:0] {
        GRP_AUX = 2'b00,
        GRP_LOC = 2'b01,
        GRP_EXT = 2'b10,
        GRP_CON = 2'b11
    } grp_e;

    typedef struct packed {
        grp_e dst;
        grp_e src_a;
        grp_e src_b;
        logic lit;
    } combo_t;

    localparam int CODE_W = 4;

    // Fixed table ordering: A destination first, then L, then X.
    function automatic combo_t combo_lookup(input logic [CODE_W-1:0] code);
        combo_t c;
        case (code)
            4'd0:    c = '{GRP_AUX, GRP_AUX, GRP_AUX, 1'b0};
            4'd1:    c = '{GRP_AUX, GRP_CON, GRP_AUX, 1'b0};
            4'd2:    c = '{GRP_LOC, GRP_LOC, GRP_LOC, 1'b0};
            4'd3:    c = '{GRP_LOC, GRP_LOC, GRP_EXT, 1'b0};
            4'd4:    c = '{GRP_LOC, GRP_EXT, GRP_LOC, 1'b0};
            4'd5:    c = '{GRP_LOC, GRP_EXT, GRP_EXT, 1'b0};
            4'd6:    c = '{GRP_LOC, GRP_CON, GRP_LOC, 1'b0};
            4'd7:    c = '{GRP_LOC, GRP_CON, GRP_EXT, 1'b0};
            4'd8:    c = '{GRP_LOC, GRP_CON, GRP_CON, 1'b1};
            4'd9:    c = '{GRP_EXT, GRP_LOC, GRP_LOC, 1'b0};
            4'd10:   c = '{GRP_EXT, GRP_LOC, GRP_EXT, 1'b0};
            4'd11:   c = '{GRP_EXT, GRP_EXT, GRP_LOC, 1'b0};
            4'd12:   c = '{GRP_EXT, GRP_EXT, GRP_EXT, 1'b0};
            4'd13:   c = '{GRP_EXT, GRP_CON, GRP_LOC, 1'b0};
            4'd14:   c = '{GRP_EXT, GRP_CON, GRP_EXT, 1'b0};
            default: c = '{GRP_EXT, GRP_CON, GRP_CON, 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/trs_combo_table.sv
// Module: trs_combo_table
// Maps the group code to the group of each operand plus the literal flag.
// Assumes the code is always one of the 16 table entries (every code is legal).
module trs_combo_table
    import trs_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output combo_t            combo_o
);

    // Table lookup: one row per group code.
    always_comb begin
        combo_o = combo_lookup(code_i);
    end

endmodule

// File: rtl/trs_operand_slot.sv
// Module: trs_operand_slot
// Builds one operand address from its group and offset and flags stack options.
// Assumes stack-option slots are the top offsets of groups A and X, and that
// both groups share one canonical address (group A) for those slots.
module trs_operand_slot
    import trs_pkg::*;
#(
    parameter int OFF_W       = 4,
    parameter int STACK_FIRST = 12,
    localparam int ADDR_W     = 2 + OFF_W
) (
    input  grp_e              grp_i,
    input  logic [OFF_W-1:0]  off_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              stack_o
);

    logic in_stack_grp;
    logic in_stack_range;

    // Stack detection: top slots of the A or X group.
    always_comb begin
        in_stack_grp   = (grp_i == GRP_AUX) || (grp_i == GRP_EXT);
        in_stack_range = (int'(off_i) >= STACK_FIRST);
        stack_o        = in_stack_grp && in_stack_range;
    end

    // Address formation: stack slots fold onto the A group.
    always_comb begin
        if (stack_o) begin
            addr_o = {GRP_AUX, off_i};
        end else begin
            addr_o = {grp_i, off_i};
        end
    end

endmodule

// File: rtl/trs_literal_unit.sv
// Module: trs_literal_unit
// Forms the immediate and the fixed left operand of a literal code.
// Assumes the immediate is {Ra offset, Rb offset}; outputs are zero when idle.
module trs_literal_unit #(
    parameter int OFF_W          = 4,
    parameter bit LEFT_ALL_ONES  = 1'b0,
    localparam int LIT_W         = 2 * OFF_W,
    localparam int LEFT_W        = LIT_W + 1
) (
    input  logic              lit_en_i,
    input  logic [OFF_W-1:0]  a_off_i,
    input  logic [OFF_W-1:0]  b_off_i,
    output logic              valid_o,
    output logic [LIT_W-1:0]  value_o,
    output logic [LEFT_W-1:0] left_o
);

    localparam logic [LEFT_W-1:0] LEFT_CONST = LEFT_ALL_ONES ? {LEFT_W{1'b1}} : '0;

    // Literal outputs: gated by the literal flag of the table.
    always_comb begin
        valid_o = lit_en_i;
        value_o = lit_en_i ? {a_off_i, b_off_i} : '0;
        left_o  = lit_en_i ? LEFT_CONST : '0;
    end

endmodule

// File: rtl/tri_reg_spec_decoder.sv
// Module: tri_reg_spec_decoder (top)
// Decodes a three-register specifier field into Rc/Ra/Rb addresses, stack
// flags and a literal immediate. Purely combinational; no clock or reset.
// Field: [15:12] group code, [11:8] Rc, [7:4] Ra, [3:0] Rb offsets.
module tri_reg_spec_decoder
    import trs_pkg::*;
#(
    parameter int OFF_W         = 4,
    parameter int STACK_FIRST   = 12,
    parameter bit LEFT_ALL_ONES = 1'b0,
    localparam int ADDR_W       = 2 + OFF_W,
    localparam int FIELD_W      = CODE_W + 3 * OFF_W,
    localparam int LIT_W        = 2 * OFF_W,
    localparam int LEFT_W       = LIT_W + 1,
    localparam int N_OPS        = 3
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [ADDR_W-1:0]  rc_addr_o,
    output logic [ADDR_W-1:0]  ra_addr_o,
    output logic [ADDR_W-1:0]  rb_addr_o,
    output logic               rc_stack_o,
    output logic               ra_stack_o,
    output logic               rb_stack_o,
    output logic               lit_valid_o,
    output logic [LIT_W-1:0]   lit_value_o,
    output logic [LEFT_W-1:0]  lit_left_o
);

    logic [CODE_W-1:0] code;
    logic [OFF_W-1:0]  off_raw [N_OPS];
    logic [OFF_W-1:0]  off_eff [N_OPS];
    grp_e              grp     [N_OPS];
    logic [ADDR_W-1:0] addr    [N_OPS];
    logic              stk     [N_OPS];
    combo_t            combo;

    // Field split: operand index 0 = Rc, 1 = Ra, 2 = Rb.
    always_comb begin
        code       = field_i[FIELD_W-1 -: CODE_W];
        off_raw[0] = field_i[3*OFF_W-1 -: OFF_W];
        off_raw[1] = field_i[2*OFF_W-1 -: OFF_W];
        off_raw[2] = field_i[OFF_W-1 -: OFF_W];
    end

    trs_combo_table u_table (
        .code_i  (code),
        .combo_o (combo)
    );

    // Operand steering: sources point at the constant-zero slot in literal codes.
    always_comb begin
        grp[0]     = combo.dst;
        grp[1]     = combo.src_a;
        grp[2]     = combo.src_b;
        off_eff[0] = off_raw[0];
        off_eff[1] = combo.lit ? '0 : off_raw[1];
        off_eff[2] = combo.lit ? '0 : off_raw[2];
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_slot
        trs_operand_slot #(
            .OFF_W       (OFF_W),
            .STACK_FIRST (STACK_FIRST)
        ) u_slot (
            .grp_i   (grp[i]),
            .off_i   (off_eff[i]),
            .addr_o  (addr[i]),
            .stack_o (stk[i])
        );
    end

    trs_literal_unit #(
        .OFF_W         (OFF_W),
        .LEFT_ALL_ONES (LEFT_ALL_ONES)
    ) u_lit (
        .lit_en_i (combo.lit),
        .a_off_i  (off_raw[1]),
        .b_off_i  (off_raw[2]),
        .valid_o  (lit_valid_o),
        .value_o  (lit_value_o),
        .left_o   (lit_left_o)
    );

    // Output mapping.
    always_comb begin
        rc_addr_o  = addr[0];
        ra_addr_o  = addr[1];
        rb_addr_o  = addr[2];
        rc_stack_o = stk[0];
        ra_stack_o = stk[1];
        rb_stack_o = stk[2];
    end

endmodule

// File: rtl/trs_checker.sv
// Module: trs_checker
// Invariant checks on the decoder ports; bound to every decoder instance.
// Assumes the default 4-bit offsets and the group encoding of trs_pkg.
module trs_checker #(
    parameter int STACK_FIRST = 12
) (
    input logic [15:0] field_i,
    input logic [5:0]  rc_addr_o,
    input logic [5:0]  ra_addr_o,
    input logic [5:0]  rb_addr_o,
    input logic        rc_stack_o,
    input logic        ra_stack_o,
    input logic        rb_stack_o,
    input logic        lit_valid_o,
    input logic [7:0]  lit_value_o,
    input logic [8:0]  lit_left_o
);

    logic aux_used;
    logic lx_used;

    // Group usage of non-stack operands.
    always_comb begin
        aux_used = (!rc_stack_o && rc_addr_o[5:4] == 2'b00)
                || (!ra_stack_o && ra_addr_o[5:4] == 2'b00)
                || (!rb_stack_o && rb_addr_o[5:4] == 2'b00);
        lx_used  = (!rc_stack_o && (rc_addr_o[5:4] == 2'b01 || rc_addr_o[5:4] == 2'b10))
                || (!ra_stack_o && (ra_addr_o[5:4] == 2'b01 || ra_addr_o[5:4] == 2'b10))
                || (!rb_stack_o && (rb_addr_o[5:4] == 2'b01 || rb_addr_o[5:4] == 2'b10));
    end

    // Port invariants.
    always_comb begin
        assert_dst_not_const_R3: assert (rc_addr_o[5:4] != 2'b11)
            else $error("Rc addressed a constant");
        assert_srcb_const_lit_R3: assert (rb_addr_o[5:4] != 2'b11 || lit_valid_o)
            else $error("Rb constant outside literal code");
        assert_no_aux_mix_R4: assert (!(aux_used && lx_used))
            else $error("A group mixed with L/X");
        assert_stack_canon_R5: assert (!rc_stack_o ||
                (rc_addr_o[5:4] == 2'b00 && int'(rc_addr_o[3:0]) >= STACK_FIRST))
            else $error("Rc stack option not canonical");
        assert_lit_sources_R7: assert (!lit_valid_o ||
                (ra_addr_o == 6'b110000 && rb_addr_o == 6'b110000 &&
                 !ra_stack_o && !rb_stack_o))
            else $error("literal sources not at constant zero");
        assert_lit_rc_field_R9: assert (!lit_valid_o || rc_addr_o[3:0] == field_i[11:8])
            else $error("Rc offset lost in literal code");
        assert_idle_lit_R8: assert (lit_valid_o || (lit_value_o == 8'd0 && lit_left_o == 9'd0))
            else $error("literal outputs active outside literal code");
    end

endmodule

bind tri_reg_spec_decoder trs_checker #(.STACK_FIRST(STACK_FIRST)) u_chk (
    .field_i     (field_i),
    .rc_addr_o   (rc_addr_o),
    .ra_addr_o   (ra_addr_o),
    .rb_addr_o   (rb_addr_o),
    .rc_stack_o  (rc_stack_o),
    .ra_stack_o  (ra_stack_o),
    .rb_stack_o  (rb_stack_o),
    .lit_valid_o (lit_valid_o),
    .lit_value_o (lit_value_o),
    .lit_left_o  (lit_left_o)
);

// File: tb/tri_reg_spec_decoder_tb.sv
// Bench: table walk over all group codes and offset patterns, then directed cases.
module tri_reg_spec_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] field;
    logic [5:0]  rc_addr, ra_addr, rb_addr;
    logic        rc_stk, ra_stk, rb_stk, lit_valid;
    logic [7:0]  lit_value;
    logic [8:0]  lit_left;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tri_reg_spec_decoder u_dut (
        .field_i     (field),
        .rc_addr_o   (rc_addr),
        .ra_addr_o   (ra_addr),
        .rb_addr_o   (rb_addr),
        .rc_stack_o  (rc_stk),
        .ra_stack_o  (ra_stk),
        .rb_stack_o  (rb_stk),
        .lit_valid_o (lit_valid),
        .lit_value_o (lit_value),
        .lit_left_o  (lit_left)
    );

    // Expected groups per code: {Rc, Ra, Rb, literal}; A=0 L=1 X=2 C=3 (R2).
    localparam logic [6:0] EXP_GRP [16] = '{
        {2'd0, 2'd0, 2'd0, 1'b0}, {2'd0, 2'd3, 2'd0, 1'b0},
        {2'd1, 2'd1, 2'd1, 1'b0}, {2'd1, 2'd1, 2'd2, 1'b0},
        {2'd1, 2'd2, 2'd1, 1'b0}, {2'd1, 2'd2, 2'd2, 1'b0},
        {2'd1, 2'd3, 2'd1, 1'b0}, {2'd1, 2'd3, 2'd2, 1'b0},
        {2'd1, 2'd3, 2'd3, 1'b1}, {2'd2, 2'd1, 2'd1, 1'b0},
        {2'd2, 2'd1, 2'd2, 1'b0}, {2'd2, 2'd2, 2'd1, 1'b0},
        {2'd2, 2'd2, 2'd2, 1'b0}, {2'd2, 2'd3, 2'd1, 1'b0},
        {2'd2, 2'd3, 2'd2, 1'b0}, {2'd2, 2'd3, 2'd3, 1'b1}
    };

    // Offset patterns {Rc, Ra, Rb}: low, high (stack), boundary.
    localparam logic [11:0] OFFS [3] = '{12'h123, 12'hDEF, 12'hBC0};

    // Expected address and stack flag of one operand (R1, R5, R6).
    function automatic logic [6:0] exp_slot(input logic [1:0] g, input logic [3:0] off);
        if ((g == 2'd0 || g == 2'd2) && off >= 4'd12) return {1'b1, 2'd0, off};
        return {1'b0, g, off};
    endfunction

    // Expected output bundle, ordered like the observed bundle below.
    function automatic logic [38:0] model(input logic [15:0] f);
        logic [6:0] e, sc, sa, sb;
        e  = EXP_GRP[f[15:12]];
        sc = exp_slot(e[6:5], f[11:8]);
        if (e[0]) begin
            return {sc[5:0], 6'b110000, 6'b110000, sc[6], 1'b0, 1'b0,
                    1'b1, f[7:4], f[3:0], 9'd0};
        end
        sa = exp_slot(e[4:3], f[7:4]);
        sb = exp_slot(e[2:1], f[3:0]);
        return {sc[5:0], sa[5:0], sb[5:0], sc[6], sa[6], sb[6], 1'b0, 8'd0, 9'd0};
    endfunction

    function automatic logic [38:0] observed();
        return {rc_addr, ra_addr, rb_addr, rc_stk, ra_stk, rb_stk,
                lit_valid, lit_value, lit_left};
    endfunction

    task automatic check(input string req, input logic [38:0] act, input logic [38:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s field=%h actual=%h expected=%h", req, field, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] f);
        @(negedge clk);
        field = f;
        #1;
    endtask

    initial begin
        field = 16'h0000;
        repeat (3) @(posedge clk);
        // R1: settled state under reset with an all-zero field.
        @(negedge clk);
        check("R1 reset", observed(), {6'd0, 6'd0, 6'd0, 3'b000, 1'b0, 8'd0, 9'd0});
        rst_n = 1'b1;

        // R2/R3/R4/R5/R6/R7/R8: table walk.
        for (int p = 0; p < 3; p++) begin
            for (int c = 0; c < 16; c++) begin
                apply({c[3:0], OFFS[p]});
                check("R2 table", observed(), model(field));
            end
        end

        // R5: stack offsets via X equal those via A.
        apply(16'hCDEF);
        begin
            logic [20:0] via_x;
            via_x = {rc_addr, ra_addr, rb_addr, rc_stk, ra_stk, rb_stk};
            apply(16'h0DEF);
            check("R5 X==A", {18'd0, via_x}, {18'd0, rc_addr, ra_addr, rb_addr, rc_stk, ra_stk, rb_stk});
            check("R5 flags", {36'd0, via_x[2:0]}, {36'd0, 3'b111});
        end

        // R6: L group offsets 12..15 are ordinary registers.
        apply(16'h2CEF);
        check("R6 L high", observed(),
              {6'h1C, 6'h1E, 6'h1F, 3'b000, 1'b0, 8'd0, 9'd0});
        // R6: offset 11 in A is not a stack option.
        apply(16'h0BBB);
        check("R6 A eleven", observed(),
              {6'h0B, 6'h0B, 6'h0B, 3'b000, 1'b0, 8'd0, 9'd0});

        // R7: literal extremes.
        apply(16'h83FF);
        check("R7 lit FF", observed(),
              {6'h13, 6'h30, 6'h30, 3'b000, 1'b1, 8'hFF, 9'd0});
        apply(16'hF000);
        check("R7 lit 00", observed(),
              {6'h20, 6'h30, 6'h30, 3'b000, 1'b1, 8'h00, 9'd0});

        // R9: Rc offset kept in literal code (X stack slot), then combinational response.
        apply(16'hFE5A);
        check("R9 rc lit", observed(),
              {6'h0E, 6'h30, 6'h30, 3'b100, 1'b1, 8'h5A, 9'd0});
        // R9 / R8: change the field mid-cycle with no clock edge in between.
        @(posedge clk);
        #1;
        field = 16'h9123;
        #1;
        check("R9 no clock", observed(),
              {6'h21, 6'h12, 6'h13, 3'b000, 1'b0, 8'd0, 9'd0});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule